// File: doc/BRIEF.md
# Single-Wire ROM Search Accelerator

This block speeds up the 64-bit identifier search on a single-wire bus. Once the bus has been reset and the search command byte has gone out, firmware turns on the accelerator mode and then trades one byte per four ROM bits with the block. Each byte written in carries four chosen path bits. For each of those bits, in order of increasing ROM bit index, the block asks a bit-slot engine for the true bit, then for its complement, and then writes the selected bit back to the bus. After four bits it returns one byte that interleaves the selected bits with discrepancy flags. Sixteen exchanges, least significant nibble first, cover one full pass. Firmware uses the discrepancy flags to pick the path for the next pass. A pass whose ROM bit 63 comes back with both the selected bit and the discrepancy flag set shows a bus error and must be run again.

The byte input and the result output are valid/ready streams. The block holds one byte in progress or one result at a time. `in_ready` is high only when mode is on, no byte is being worked and no result is waiting. A result stays on `out_data` with `out_valid` high until `out_ready` takes it, and no new byte is accepted before then. The bit-slot engine uses a request/done pair. The request and its operation stay fixed until the engine returns done.

Top module: `romsrch_accel`

## Requirements
- R1: While `mode_en` is low, `in_ready`, `out_valid` and `slot_req` are low and no byte is accepted. Dropping `mode_en` in the middle of a byte or a pass discards that work, and the next byte after mode returns starts a new pass.
- R2: In an input byte, path bits for ROM bits 0..3 of the nibble are taken from byte bits 1, 3, 5 and 7. Bits 0, 2, 4 and 6 have no effect.
- R3: For each ROM bit, the slot sequence is a read (true bit), then a read (complement), then a write of the selected bit (`slot_op` 0 = read, 1 = write). The four bits of a byte are handled in increasing index order.
- R4: When the true bit and the complement differ, the selected bit equals the true bit and the discrepancy flag is 0.
- R5: When the true bit and the complement both read 0, the discrepancy flag is 1, and the selected bit and the bit written back equal the path bit.
- R6: When the true bit and the complement both read 1, that bit and every later bit of the same pass return selected = 1 and discrepancy = 1. No write slot follows, and no further slots are requested in that pass.
- R7: Result byte bits 1, 3, 5 and 7 carry the selected ROM bits 0..3 of the nibble. Bits 0, 2, 4 and 6 carry their discrepancy flags. `out_valid` rises only after the fourth bit is finished.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and `in_ready` stays low.
- R9: A pass is sixteen accepted result bytes. After the sixteenth result the no-answer state of R6 is cleared, so the next byte starts a new pass.
- R10: `slot_req`, `slot_op` and `slot_wbit` stay steady from the raising of a request until the cycle in which `slot_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Accelerator mode on |
| in_valid | input | 1 | Path byte valid |
| in_ready | output | 1 | Path byte can be taken |
| in_data | input | 8 | Path byte, path bits at odd positions |
| out_valid | output | 1 | Result byte valid |
| out_ready | input | 1 | Result byte taken |
| out_data | output | 8 | Result byte: selected bits odd, discrepancy flags even |
| slot_req | output | 1 | Bit-slot request |
| slot_op | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_done | input | 1 | Slot finished (read data valid) |
| slot_rbit | input | 1 | Bit read in a read slot |

## Verification
The hardest case to reach is the state where no device answers, which must stay set for the rest of the pass and then be forgotten. The bench reaches it by running a whole pass with no modelled devices on the bus. It then runs a pass with devices present and expects normal results from its very first byte. It also drops the mode partway through a silent pass and again expects a clean next pass. Discrepancy handling is driven by a bus model with two devices whose identifiers differ in two bit positions. The bench runs that model under different path vectors, with the even input bits set to junk.

// File: rtl/romsrch_pkg.sv
package romsrch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TRUE,
    ST_RD_CMPL,
    ST_WR,
    ST_HOLD
  } srch_state_t;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;
endpackage

// File: rtl/romsrch_lanes.sv
module romsrch_lanes #(
  parameter int GROUP = 4
) (
  input  logic [2*GROUP-1:0] byte_in,
  output logic [GROUP-1:0]   path_out,
  input  logic [GROUP-1:0]   sel_in,
  input  logic [GROUP-1:0]   disc_in,
  output logic [2*GROUP-1:0] byte_out
);
  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    assign path_out[g]       = byte_in[2*g+1];
    assign byte_out[2*g+1]   = sel_in[g];
    assign byte_out[2*g]     = disc_in[g];
  end

  logic unused_even;
  always_comb begin
    unused_even = 1'b0;
    for (int g = 0; g < GROUP; g++) unused_even = unused_even ^ byte_in[2*g];
  end
endmodule

// File: rtl/romsrch_decide.sv
module romsrch_decide (
  input  logic true_bit,
  input  logic cmpl_bit,
  input  logic path_bit,
  input  logic dead_in,
  output logic sel_bit,
  output logic disc_bit,
  output logic dead_out
);
  always_comb begin
    if (dead_in || (true_bit && cmpl_bit)) begin
      sel_bit  = 1'b1;
      disc_bit = 1'b1;
      dead_out = 1'b1;
    end else if (!true_bit && !cmpl_bit) begin
      sel_bit  = path_bit;
      disc_bit = 1'b1;
      dead_out = 1'b0;
    end else begin
      sel_bit  = true_bit;
      disc_bit = 1'b0;
      dead_out = 1'b0;
    end
  end
endmodule

// File: rtl/romsrch_ctrl.sv
module romsrch_ctrl
  import romsrch_pkg::*;
#(
  parameter int GROUP    = 4,
  parameter int ROM_BITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic             in_fire,
  input  logic [GROUP-1:0] path_in,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [GROUP-1:0] sel_vec,
  output logic [GROUP-1:0] disc_vec,
  output logic             slot_req,
  output logic             slot_op,
  output logic             slot_wbit,
  input  logic             slot_done,
  input  logic             slot_rbit
);
  localparam int NIBBLES = ROM_BITS / GROUP;
  localparam int NIB_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
  localparam int K_W     = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [NIB_W-1:0] NIB_LAST = NIB_W'(NIBBLES - 1);
  localparam logic [K_W-1:0]   K_LAST   = K_W'(GROUP - 1);

  srch_state_t      st_q;
  logic [K_W-1:0]   k_q;
  logic [NIB_W-1:0] nib_q;
  logic [GROUP-1:0] path_q, sel_q, disc_q;
  logic             t_q, dead_q;
  logic             d_sel, d_disc, d_dead;

  romsrch_decide u_decide (
    .true_bit (t_q),
    .cmpl_bit (slot_rbit),
    .path_bit (path_q[k_q]),
    .dead_in  (dead_q),
    .sel_bit  (d_sel),
    .disc_bit (d_disc),
    .dead_out (d_dead)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      nib_q  <= '0;
      path_q <= '0;
      sel_q  <= '0;
      disc_q <= '0;
      t_q    <= 1'b0;
      dead_q <= 1'b0;
    end else if (!mode_en) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      nib_q  <= '0;
      dead_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_fire) begin
          path_q <= path_in;
          k_q    <= '0;
          sel_q  <= '0;
          disc_q <= '0;
          st_q   <= ST_RD_TRUE;
        end
        ST_RD_TRUE: begin
          if (dead_q) begin
            sel_q[k_q]  <= 1'b1;
            disc_q[k_q] <= 1'b1;
            if (k_q == K_LAST) st_q <= ST_HOLD;
            else begin
              k_q  <= k_q + K_W'(1);
              st_q <= ST_RD_TRUE;
            end
          end else if (slot_done) begin
            t_q  <= slot_rbit;
            st_q <= ST_RD_CMPL;
          end
        end
        ST_RD_CMPL: if (slot_done) begin
          sel_q[k_q]  <= d_sel;
          disc_q[k_q] <= d_disc;
          dead_q      <= d_dead;
          if (!d_dead) st_q <= ST_WR;
          else if (k_q == K_LAST) st_q <= ST_HOLD;
          else begin
            k_q  <= k_q + K_W'(1);
            st_q <= ST_RD_TRUE;
          end
        end
        ST_WR: if (slot_done) begin
          if (k_q == K_LAST) st_q <= ST_HOLD;
          else begin
            k_q  <= k_q + K_W'(1);
            st_q <= ST_RD_TRUE;
          end
        end
        ST_HOLD: if (out_ready) begin
          if (nib_q == NIB_LAST) begin
            nib_q  <= '0;
            dead_q <= 1'b0;
          end else begin
            nib_q <= nib_q + NIB_W'(1);
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = mode_en && (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign sel_vec   = sel_q;
  assign disc_vec  = disc_q;
  assign slot_req  = ((st_q == ST_RD_TRUE) && !dead_q) ||
                     (st_q == ST_RD_CMPL) || (st_q == ST_WR);
  assign slot_op   = (st_q == ST_WR) ? OP_WRITE : OP_READ;
  assign slot_wbit = (st_q == ST_WR) ? sel_q[k_q] : 1'b0;
endmodule

// File: rtl/romsrch_accel.sv
module romsrch_accel #(
  parameter int GROUP    = 4,
  parameter int ROM_BITS = 64,
  localparam int BW      = 2 * GROUP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_data,
  output logic          slot_req,
  output logic          slot_op,
  output logic          slot_wbit,
  input  logic          slot_done,
  input  logic          slot_rbit
);
  logic [GROUP-1:0] path_vec, sel_vec, disc_vec;
  logic             in_fire;

  assign in_fire = in_valid && in_ready;

  romsrch_lanes #(.GROUP(GROUP)) u_lanes (
    .byte_in  (in_data),
    .path_out (path_vec),
    .sel_in   (sel_vec),
    .disc_in  (disc_vec),
    .byte_out (out_data)
  );

  romsrch_ctrl #(.GROUP(GROUP), .ROM_BITS(ROM_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .in_fire   (in_fire),
    .path_in   (path_vec),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .sel_vec   (sel_vec),
    .disc_vec  (disc_vec),
    .slot_req  (slot_req),
    .slot_op   (slot_op),
    .slot_wbit (slot_wbit),
    .slot_done (slot_done),
    .slot_rbit (slot_rbit)
  );
endmodule

// File: rtl/romsrch_accel_chk.sv
module romsrch_accel_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_en,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [BW-1:0] out_data,
  input logic          slot_req,
  input logic          slot_op,
  input logic          slot_wbit,
  input logic          slot_done
);
  // R10: a pending slot request keeps its operation and data
  a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_done && mode_en) |=>
      (!mode_en || (slot_req && $stable(slot_op) && $stable(slot_wbit))));

  // R8: a waiting result is held steady
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && mode_en) |=>
      (!mode_en || (out_valid && $stable(out_data))));

  // R8: no byte accepted while work or a result is outstanding
  a_r8_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !slot_req));

  // R1: mode off empties the block on the next cycle
  a_r1_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!out_valid && !slot_req));

  // R1: no byte can be taken with the mode off
  a_r1_ready_mode: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> mode_en);
endmodule

bind romsrch_accel romsrch_accel_chk #(.BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_en   (mode_en),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .slot_req  (slot_req),
  .slot_op   (slot_op),
  .slot_wbit (slot_wbit),
  .slot_done (slot_done)
);

// File: tb/romsrch_accel_tb.sv
module romsrch_accel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       mode_en = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, slot_req, slot_op, slot_wbit;
  logic [7:0] out_data;
  logic       slot_done = 1'b0, slot_rbit = 1'b0;

  romsrch_accel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .slot_req(slot_req), .slot_op(slot_op), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---- bus model: up to two devices, wired-AND reads ----
  logic [63:0] rom [2];
  bit          present [2];
  bit          active [2];
  int          pos, rd_phase, slot_cnt, seq_err;

  function automatic bit bus_true(int p);
    bit v = 1'b1;
    for (int i = 0; i < 2; i++) if (active[i]) v &= rom[i][p];
    return v;
  endfunction
  function automatic bit bus_cmpl(int p);
    bit v = 1'b1;
    for (int i = 0; i < 2; i++) if (active[i]) v &= ~rom[i][p];
    return v;
  endfunction

  always @(negedge clk) begin
    if (slot_req && !slot_done) begin
      slot_done = 1'b1;
      slot_cnt++;
      if (slot_op == 1'b0) begin
        if (rd_phase >= 2) seq_err++;
        slot_rbit = (rd_phase == 0) ? bus_true(pos) : bus_cmpl(pos);
        rd_phase++;
      end else begin
        if (rd_phase != 2) seq_err++;
        for (int i = 0; i < 2; i++)
          if (active[i] && rom[i][pos] != slot_wbit) active[i] = 1'b0;
        pos++;
        rd_phase = 0;
      end
    end else begin
      slot_done = 1'b0;
    end
  end

  // ---- expectation model, kept apart from the bus model ----
  bit exp_act [2];
  bit exp_dead;
  int exp_pos;

  task automatic pass_start();
    for (int i = 0; i < 2; i++) begin
      active[i]  = present[i];
      exp_act[i] = present[i];
    end
    pos = 0; rd_phase = 0; exp_pos = 0; exp_dead = 0;
  endtask

  task automatic exp_byte(input logic [3:0] path, output logic [7:0] eb, output int eslots);
    eb = '0; eslots = 0;
    for (int k = 0; k < 4; k++) begin
      bit t = 1'b1, c = 1'b1, s, d;
      if (exp_dead) begin s = 1; d = 1; end
      else begin
        for (int i = 0; i < 2; i++) if (exp_act[i]) begin
          t &= rom[i][exp_pos]; c &= ~rom[i][exp_pos];
        end
        eslots += 2;
        if (t && c) begin s = 1; d = 1; exp_dead = 1; end
        else begin
          if (!t && !c) begin s = path[k]; d = 1; end
          else begin s = t; d = 0; end
          eslots += 1;
          for (int i = 0; i < 2; i++) if (exp_act[i] && rom[i][exp_pos] != s) exp_act[i] = 0;
          exp_pos++;
        end
      end
      eb[2*k+1] = s; eb[2*k] = d;
    end
  endtask

  function automatic logic [7:0] mk_byte(logic [3:0] p, bit junk);
    logic [7:0] b = junk ? 8'h55 : 8'h00;
    for (int k = 0; k < 4; k++) b[2*k+1] = p[k];
    return b;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    forever begin @(negedge clk); if (in_ready) break; end
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    while (!out_valid) @(negedge clk);
    b = out_data;
  endtask

  // R2 R3 R4 R5 R7 R9: one full pass of sixteen exchanges
  task automatic run_pass(input logic [63:0] path, input bit junk, input string tag);
    logic [7:0] eb, got;
    int eslots;
    pass_start();
    for (int n = 0; n < 16; n++) begin
      slot_cnt = 0; seq_err = 0;
      send_byte(mk_byte(path[4*n +: 4], junk));
      exp_byte(path[4*n +: 4], eb, eslots);
      get_byte(got);
      check(got == eb, $sformatf("R7 %s nibble %0d", tag, n), got, eb);
      check(slot_cnt == eslots, $sformatf("R3 %s slots nibble %0d", tag, n), slot_cnt, eslots);
      check(seq_err == 0, $sformatf("R3 %s order nibble %0d", tag, n), seq_err, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_and_off();
    check(!in_ready && !out_valid && !slot_req, "R1 reset state",
          {in_ready, out_valid, slot_req}, 0);
    in_valid = 1'b1; in_data = 8'hAA;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!in_ready && !slot_req && !out_valid, "R1 mode off ignores input",
            {in_ready, slot_req, out_valid}, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_one_device();
    present[0] = 1; present[1] = 0;
    mode_en = 1'b1;
    run_pass(64'h0, 1'b0, "R4 single device");
    run_pass(64'hFFFF_0000_FFFF_0000, 1'b1, "R2 single device junk");
  endtask

  task automatic t_two_devices();
    present[0] = 1; present[1] = 1;
    run_pass(64'h0, 1'b1, "R5 two devices path0");
    run_pass(64'h0000_0100_0000_0020, 1'b0, "R5 two devices path1");
    run_pass(64'h0000_0000_0000_0020, 1'b1, "R5 two devices mixed");
  endtask

  task automatic t_silent_then_present();
    present[0] = 0; present[1] = 0;
    run_pass(64'h0, 1'b0, "R6 silent");
    present[0] = 1; present[1] = 1;
    run_pass(64'h0, 1'b0, "R9 after silent pass");
  endtask

  task automatic t_mode_drop();
    logic [7:0] got;
    present[0] = 0; present[1] = 0;
    pass_start();
    send_byte(8'h00); get_byte(got);
    check(got == 8'hFF, "R6 silent first byte", got, 8'hFF);
    @(negedge clk);
    send_byte(8'h00);
    mode_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!out_valid && !slot_req && !in_ready, "R1 mode drop clears",
          {out_valid, slot_req, in_ready}, 0);
    mode_en = 1'b1;
    present[0] = 1; present[1] = 1;
    run_pass(64'h0000_0100_0000_0000, 1'b0, "R1 pass after mode drop");
  endtask

  task automatic t_backpressure();
    logic [7:0] first;
    present[0] = 1; present[1] = 0;
    pass_start();
    out_ready = 1'b0;
    send_byte(8'h00);
    get_byte(first);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_valid && out_data == first && !in_ready, "R8 held under back-pressure",
            {out_valid, in_ready, out_data}, {2'b10, first});
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R8 released after take", {out_valid, in_ready}, 2'b01);
    mode_en = 1'b0;
    @(negedge clk);
    mode_en = 1'b1;
  endtask

  initial begin
    rom[0] = 64'hA5C3_19F0_7E42_8B16;
    rom[1] = rom[0] ^ (64'h1 << 5) ^ (64'h1 << 40);
    present[0] = 0; present[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_off();
    t_one_device();
    t_two_devices();
    t_silent_then_present();
    t_mode_drop();
    t_backpressure();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule